// File: doc/BRIEF.md
# Pulse-and-Verify Byte Programming Controller

This controller writes a block of bytes into an erasable non-volatile memory whose erased cells read as all ones. Programming can only clear bits. A single start request begins the run. The controller walks the addresses in ascending order and fetches each target byte from a byte source indexed by the memory address output.

For each target byte the controller first sets up address and data. It then drives a low program strobe for a fixed number of clock cycles, releases it, and reads the location back in verify mode. The pulse-and-read step repeats until the byte matches or a bounded number of pulses has been spent. Targets that are already all ones need no pulse.

Once every byte has been handled, the controller drops the high-supply flag. It then reads the whole array once more and compares it against the source. When it stops, it raises `done` together with a pass/fail status, the first failing address and the number of pulses spent on that address.

Top module: `pulse_burn_ctrl`

## Requirements
- R1: After reset, and while idle, `ceN`, `oeN` and `pgmN` are high, `hiVolt` is low and `done` is low.
- R2: Every program pulse keeps `pgmN` low for exactly `PULSE_CYC` consecutive cycles. Throughout the pulse, `ceN` is low, `oeN` is high and `hiVolt` is high.
- R3: The cycle before `pgmN` falls and the cycle after it rises both have `pgmN` high, `ceN` low and `oeN` high. `memAddr` and `memWrData` hold the same values from that setup cycle through that hold cycle.
- R4: Each pulse is followed by exactly one verify read with `ceN` low, `oeN` low, `pgmN` high and `hiVolt` high. `pgmN` and `oeN` are never low together.
- R5: A byte is pulsed again after each mismatching verify read. A byte that first reads correctly after n pulses (n ≤ `MAX_PULSES`) receives exactly n pulses.
- R6: No byte gets more than `MAX_PULSES` (default 10) pulses. If the verify read after the last allowed pulse still mismatches, the controller stops: it pulses no later address, raises `done` with `pass` low, `failAddr` set to that address and `failPulses` = `MAX_PULSES`.
- R7: A target byte of all ones (8'hFF) receives no pulse and no verify read.
- R8: After the last address, the controller reads every address from 0 upward, one per cycle, with `ceN` low, `oeN` low and `hiVolt` low. It compares each read with the source byte. The first mismatch stops the run with `pass` low, `failAddr` set to that address and `failPulses` = 0.
- R9: A run with no mismatch ends with `done` and `pass` high. `done` and the status stay unchanged while idle and are cleared in the cycle after `start` is sampled.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a programming run (sampled while idle) |
| srcData | input | DATA_W | Target byte for the location on `memAddr` |
| rdData | input | DATA_W | Byte read back from the memory |
| done | output | 1 | Run finished; held until the next start |
| pass | output | 1 | Run finished without failure |
| failAddr | output | ADDR_W | Address at which the run failed |
| failPulses | output | PCNT_W | Pulses applied at the failing address (0 for a final-pass failure) |
| memAddr | output | ADDR_W | Memory address, also the byte source index |
| memWrData | output | DATA_W | Data presented to the memory during programming |
| ceN | output | 1 | Active-low chip enable |
| oeN | output | 1 | Active-low output enable |
| pgmN | output | 1 | Active-low program strobe |
| hiVolt | output | 1 | Programming supplies raised |

## Verification
The bench drives a behavioural memory model in which every location needs its own number of pulses before its bits clear. Four patterns are run against it.

A mixed image with an all-ones byte, with pulse needs from 1 up to exactly the limit, separates correct retry counting and skipping from off-by-one pulse budgets. A location that needs one pulse more than the limit shows whether the controller stops at the right count and leaves later addresses untouched. A location that reads correctly only at high supply passes every per-byte verify but must be caught by the final pass. An all-ones image checks that nothing is pulsed at all.

// File: rtl/pulse_burn_pkg.sv
package pulse_burn_pkg;

  // Strobes from the sequencer to the datapath
  typedef struct packed {
    logic runClr;    // clear failure record at run start
    logic addrClr;   // address back to zero
    logic addrInc;   // advance address
    logic tgtLoad;   // capture the target byte
    logic pulseClr;  // reset per-byte pulse count
    logic pulseInc;  // one more pulse on this byte
    logic timerClr;  // restart pulse timer
    logic timerRun;  // pulse timer counting (strobe low)
    logic finalCmp;  // compare against the source, not the target
    logic failRec;   // record failing address and count
  } dpCtrl_t;

  // Conditions reported back by the datapath
  typedef struct packed {
    logic tgtErased;  // source byte is all ones
    logic timerDone;  // last cycle of the pulse
    logic addrLast;   // on the last address
    logic match;      // read-back equals the reference byte
    logic pulsesMax;  // pulse budget spent
  } dpStat_t;

  typedef enum logic [2:0] {
    S_IDLE, S_LOAD, S_SETUP, S_PULSE, S_HOLD, S_VREAD, S_NEXT, S_FREAD
  } burnState_t;

endpackage

// File: rtl/pulse_burn_path.sv
module pulse_burn_path
  import pulse_burn_pkg::*;
#(
  parameter int ADDR_W     = 4,
  parameter int DATA_W     = 8,
  parameter int PULSE_CYC  = 20000,
  parameter int MAX_PULSES = 10,
  parameter int PCNT_W     = $clog2(MAX_PULSES + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpCtrl_t           ctrl,
  input  logic [DATA_W-1:0] srcData,
  input  logic [DATA_W-1:0] rdData,
  output dpStat_t           stat,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWrData,
  output logic [ADDR_W-1:0] failAddr,
  output logic [PCNT_W-1:0] failPulses
);

  localparam int TMR_W = $clog2(PULSE_CYC + 1);
  localparam logic [TMR_W-1:0]  TMR_END  = TMR_W'(PULSE_CYC - 1);
  localparam logic [PCNT_W-1:0] PCNT_MAX = PCNT_W'(MAX_PULSES);

  logic [ADDR_W-1:0] addr;
  logic [DATA_W-1:0] target;
  logic [PCNT_W-1:0] pulseCnt;
  logic [TMR_W-1:0]  timer;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addr       <= '0;
      target     <= '1;
      pulseCnt   <= '0;
      timer      <= '0;
      failAddr   <= '0;
      failPulses <= '0;
    end else begin
      if (ctrl.addrClr)      addr <= '0;
      else if (ctrl.addrInc) addr <= addr + 1'b1;

      if (ctrl.tgtLoad) target <= srcData;

      if (ctrl.pulseClr)      pulseCnt <= '0;
      else if (ctrl.pulseInc) pulseCnt <= pulseCnt + 1'b1;

      if (ctrl.timerClr)      timer <= '0;
      else if (ctrl.timerRun) timer <= timer + 1'b1;

      if (ctrl.runClr) begin
        failAddr   <= '0;
        failPulses <= '0;
      end else if (ctrl.failRec) begin
        failAddr   <= addr;
        failPulses <= ctrl.finalCmp ? '0 : pulseCnt;
      end
    end
  end

  always_comb begin
    stat.tgtErased = &srcData;
    stat.timerDone = (timer == TMR_END);
    stat.addrLast  = &addr;
    stat.match     = ctrl.finalCmp ? (rdData == srcData) : (rdData == target);
    stat.pulsesMax = (pulseCnt == PCNT_MAX);
  end

  assign memAddr   = addr;
  assign memWrData = target;

  // R6
  pulse_cap_chk: assert property (@(posedge clk) disable iff (!rstN)
    pulseCnt <= PCNT_MAX);

  // R2
  pulse_len_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.timerRun |-> (timer <= TMR_END));

  // R3
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.timerRun |=> ($stable(addr) && $stable(target)));

endmodule

// File: rtl/pulse_burn_fsm.sv
module pulse_burn_fsm
  import pulse_burn_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    start,
  input  dpStat_t stat,
  output dpCtrl_t ctrl,
  output logic    ceN,
  output logic    oeN,
  output logic    pgmN,
  output logic    hiVolt,
  output logic    done,
  output logic    pass
);

  burnState_t state, nextState;
  logic finishOk, finishBad;

  always_comb begin
    nextState = state;
    ctrl      = '0;
    finishOk  = 1'b0;
    finishBad = 1'b0;
    ceN = 1'b1; oeN = 1'b1; pgmN = 1'b1; hiVolt = 1'b1;
    case (state)
      S_IDLE: begin
        hiVolt = 1'b0;
        if (start) begin
          ctrl.runClr  = 1'b1;
          ctrl.addrClr = 1'b1;
          nextState    = S_LOAD;
        end
      end
      S_LOAD: begin
        ctrl.tgtLoad  = 1'b1;
        ctrl.pulseClr = 1'b1;
        nextState     = stat.tgtErased ? S_NEXT : S_SETUP;
      end
      S_SETUP: begin
        ceN           = 1'b0;
        ctrl.timerClr = 1'b1;
        ctrl.pulseInc = 1'b1;
        nextState     = S_PULSE;
      end
      S_PULSE: begin
        ceN           = 1'b0;
        pgmN          = 1'b0;
        ctrl.timerRun = 1'b1;
        if (stat.timerDone) nextState = S_HOLD;
      end
      S_HOLD: begin
        ceN       = 1'b0;
        nextState = S_VREAD;
      end
      S_VREAD: begin
        ceN = 1'b0;
        oeN = 1'b0;
        if (stat.match) nextState = S_NEXT;
        else if (stat.pulsesMax) begin
          ctrl.failRec = 1'b1;
          finishBad    = 1'b1;
          nextState    = S_IDLE;
        end else nextState = S_SETUP;
      end
      S_NEXT: begin
        if (stat.addrLast) begin
          ctrl.addrClr = 1'b1;
          nextState    = S_FREAD;
        end else begin
          ctrl.addrInc = 1'b1;
          nextState    = S_LOAD;
        end
      end
      S_FREAD: begin
        ceN           = 1'b0;
        oeN           = 1'b0;
        hiVolt        = 1'b0;
        ctrl.finalCmp = 1'b1;
        if (!stat.match) begin
          ctrl.failRec = 1'b1;
          finishBad    = 1'b1;
          nextState    = S_IDLE;
        end else if (stat.addrLast) begin
          finishOk  = 1'b1;
          nextState = S_IDLE;
        end else ctrl.addrInc = 1'b1;
      end
      default: nextState = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= S_IDLE;
      done  <= 1'b0;
      pass  <= 1'b0;
    end else begin
      state <= nextState;
      if (ctrl.runClr) begin
        done <= 1'b0;
        pass <= 1'b0;
      end else if (finishOk || finishBad) begin
        done <= 1'b1;
        pass <= finishOk;
      end
    end
  end

  // R2
  strobe_mode_chk: assert property (@(posedge clk) disable iff (!rstN)
    !pgmN |-> (!ceN && oeN && hiVolt));

  // R4
  no_contention_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(!pgmN && !oeN));

  // R3
  hold_after_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(pgmN) |-> (!ceN && oeN));

  // R9
  done_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (state == S_IDLE));

  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_IDLE) |-> (ceN && oeN && pgmN && !hiVolt));

endmodule

// File: rtl/pulse_burn_ctrl.sv
module pulse_burn_ctrl
  import pulse_burn_pkg::*;
#(
  parameter int ADDR_W     = 4,
  parameter int DATA_W     = 8,
  parameter int PULSE_CYC  = 20000,
  parameter int MAX_PULSES = 10,
  parameter int PCNT_W     = $clog2(MAX_PULSES + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [DATA_W-1:0] srcData,
  input  logic [DATA_W-1:0] rdData,
  output logic              done,
  output logic              pass,
  output logic [ADDR_W-1:0] failAddr,
  output logic [PCNT_W-1:0] failPulses,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWrData,
  output logic              ceN,
  output logic              oeN,
  output logic              pgmN,
  output logic              hiVolt
);

  dpCtrl_t ctrl;
  dpStat_t stat;

  pulse_burn_fsm u_fsm (
    .clk    (clk),
    .rstN   (rstN),
    .start  (start),
    .stat   (stat),
    .ctrl   (ctrl),
    .ceN    (ceN),
    .oeN    (oeN),
    .pgmN   (pgmN),
    .hiVolt (hiVolt),
    .done   (done),
    .pass   (pass)
  );

  pulse_burn_path #(
    .ADDR_W     (ADDR_W),
    .DATA_W     (DATA_W),
    .PULSE_CYC  (PULSE_CYC),
    .MAX_PULSES (MAX_PULSES),
    .PCNT_W     (PCNT_W)
  ) u_path (
    .clk        (clk),
    .rstN       (rstN),
    .ctrl       (ctrl),
    .srcData    (srcData),
    .rdData     (rdData),
    .stat       (stat),
    .memAddr    (memAddr),
    .memWrData  (memWrData),
    .failAddr   (failAddr),
    .failPulses (failPulses)
  );

endmodule

// File: tb/pulse_burn_ctrl_bench.sv
module pulse_burn_ctrl_bench;

  localparam int AW = 3;
  localparam int N  = 1 << AW;
  localparam int P  = 6;
  localparam int MX = 10;
  localparam int PW = $clog2(MX + 1);

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0;
  logic [7:0] srcData, rdData;
  logic done, pass, ceN, oeN, pgmN, hiVolt;
  logic [AW-1:0] failAddr, memAddr;
  logic [PW-1:0] failPulses;
  logic [7:0] memWrData;

  always #2.5 clk = ~clk;

  pulse_burn_ctrl #(.ADDR_W(AW), .DATA_W(8), .PULSE_CYC(P), .MAX_PULSES(MX)) u_pulse_burn_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .srcData(srcData), .rdData(rdData),
    .done(done), .pass(pass), .failAddr(failAddr), .failPulses(failPulses),
    .memAddr(memAddr), .memWrData(memWrData), .ceN(ceN), .oeN(oeN),
    .pgmN(pgmN), .hiVolt(hiVolt));

  // behavioural memory and source
  logic [7:0] src [N];
  logic [7:0] mem [N];
  int need [N];
  bit leak [N];
  int pulses [N];
  int vreads [N];
  int finalIdx;

  int checks = 0;
  int failures = 0;

  assign srcData = src[memAddr];
  always_comb begin
    if (!ceN && !oeN)
      rdData = mem[memAddr] ^ ((leak[memAddr] && !hiVolt) ? 8'h01 : 8'h00);
    else
      rdData = 8'h5A;
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // per-clock reference checking of the memory-side protocol
  logic pPgm = 1'b1, pCe = 1'b1, pOe = 1'b1;
  logic [AW-1:0] pAddr = '0;
  logic [7:0] pData = '0;
  int width = 0;

  always @(negedge clk) begin
    if (rstN) begin
      chk(!(!pgmN && !oeN), "R4 strobe and output enable both low", int'(oeN), 1);
      if (!pgmN) begin
        width++;
        chk(!ceN && oeN && hiVolt, "R2 pulse mode", {ceN, oeN, hiVolt}, 3'b011);
        if (pPgm)
          chk(!pCe && pOe && pAddr == memAddr && pData == memWrData,
              "R3 setup before strobe", int'(pAddr), int'(memAddr));
        else
          chk(pAddr == memAddr && pData == memWrData, "R3 stable in pulse",
              int'(memAddr), int'(pAddr));
      end
      if (pgmN && !pPgm) begin
        chk(width == P, "R2 pulse width", width, P);
        width = 0;
        chk(!ceN && oeN && memAddr == pAddr && memWrData == pData,
            "R3 hold after strobe", int'(memAddr), int'(pAddr));
        pulses[pAddr]++;
        if (pulses[pAddr] >= need[pAddr]) mem[pAddr] = mem[pAddr] & pData;
      end
      if (!oeN && hiVolt) begin
        chk(!ceN && pgmN, "R4 verify mode", {ceN, pgmN}, 2'b01);
        vreads[memAddr]++;
      end
      if (!oeN && !hiVolt) begin
        chk(!ceN && int'(memAddr) == finalIdx, "R8 final read order", int'(memAddr), finalIdx);
        finalIdx++;
      end
    end
    pPgm = pgmN; pCe = ceN; pOe = oeN; pAddr = memAddr; pData = memWrData;
  end

  task automatic prep();
    for (int i = 0; i < N; i++) begin
      mem[i] = 8'hFF; pulses[i] = 0; vreads[i] = 0; leak[i] = 1'b0;
    end
    finalIdx = 0;
  endtask

  task automatic runCase(input string name);
    bit expPass;
    int expAddr, expPulses, expFinal, stopAt, cnt;
    // expected outcome from the requirements
    expPass = 1; expAddr = 0; expPulses = 0; stopAt = N; expFinal = 0;
    for (int i = 0; i < N; i++) begin
      if (expPass && src[i] != 8'hFF && need[i] > MX) begin
        expPass = 0; expAddr = i; expPulses = MX; stopAt = i;
      end
    end
    if (expPass) begin
      expFinal = N;
      for (int i = N - 1; i >= 0; i--)
        if (leak[i] && src[i][0] == 1'b0 || leak[i]) begin
          expPass = 0; expAddr = i; expPulses = 0; expFinal = i + 1;
        end
    end
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    chk(done == 1'b0, {"R9 done cleared by start ", name}, int'(done), 0);
    cnt = 0;
    while (!done && cnt < 20000) begin
      @(negedge clk); cnt++;
    end
    if (!done) chk(1'b0, {"R9 watchdog ", name}, cnt, 20000);
    chk(pass == expPass, {"R9 pass status ", name}, int'(pass), int'(expPass));
    if (!expPass) begin
      chk(int'(failAddr) == expAddr, {"R6 R8 failing address ", name}, int'(failAddr), expAddr);
      chk(int'(failPulses) == expPulses, {"R6 R8 failing pulse count ", name}, int'(failPulses), expPulses);
    end
    for (int i = 0; i < N; i++) begin
      int e;
      if (i > stopAt || src[i] == 8'hFF) e = 0;
      else if (need[i] > MX) e = MX;
      else e = need[i];
      chk(pulses[i] == e, {"R5 R6 R7 pulses per address ", name}, pulses[i], e);
      chk(vreads[i] == pulses[i], {"R4 one verify per pulse ", name}, vreads[i], pulses[i]);
    end
    chk(finalIdx == expFinal, {"R8 final read count ", name}, finalIdx, expFinal);
    repeat (5) @(negedge clk);
    chk(done && pass == expPass && ceN && oeN && pgmN && !hiVolt,
        {"R9 R1 status held while idle ", name}, int'(done), 1);
  endtask

  initial begin
    for (int i = 0; i < N; i++) begin src[i] = 8'hFF; need[i] = 1; end
    prep();
    repeat (3) @(negedge clk);
    chk(ceN && oeN && pgmN && !hiVolt && !done, "R1 reset state", int'(done), 0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    chk(ceN && oeN && pgmN && !hiVolt && !done, "R1 idle after reset", int'(done), 0);

    // mixed image, budget boundary, one erased byte
    src[0] = 8'h12; src[1] = 8'h34; src[2] = 8'hFF; src[3] = 8'h00;
    src[4] = 8'h5A; src[5] = 8'hA5; src[6] = 8'h80; src[7] = 8'h7F;
    need[0] = 1; need[1] = 3; need[2] = 1; need[3] = 10;
    need[4] = 2; need[5] = 1; need[6] = 5; need[7] = 4;
    prep();
    runCase("mixed");

    // one location beyond the pulse budget
    prep();
    need[5] = 11;
    runCase("stuck");

    // location that only verifies at high supply
    prep();
    need[5] = 1;
    leak[3] = 1'b1;
    runCase("leak");

    // fully erased image
    prep();
    for (int i = 0; i < N; i++) src[i] = 8'hFF;
    runCase("blank");

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule